// File: doc/BRIEF.md
# Banked Scratchpad Write Router

The router sits between two write requesters, a DMA load engine and a vector compute unit, and a banked scratchpad. Each requester sends a write as two consecutive 64-bit halves: the low half together with a header (reorder-buffer tag, virtual bank id, start address), then the high half. The router packs the halves into one 128-bit beat, translates the virtual bank into a physical bank, and checks a per-bank hold vector. The hold vector stands in for the dependency scoreboard. A write whose bank is clear enters a shared write queue. A write whose bank is held waits in a per-source park slot until the hold drops. The queue drains one write per cycle towards the banks, and only the physical bank, the address and the data are sent.

Each requester may also leave one read waiting in a read slot. Reads go to the banks only in a cycle that also forwards a write, and only when their bank is clear. Every issued read records its requester in a small tag FIFO. Bank read responses are then steered back to the requester named by the oldest recorded tag.

Top module: `spwr_router`

## Requirements
- R1: After reset, `idle` is 1, all valid outputs are 0, and both write-ready and both read-ready outputs are 1.
- R2: A write is two beats on consecutive cycles: a first beat accepted with `*WrReady`=1 carries the header and data bits [63:0], and the very next beat carries bits [127:64]. The forwarded `bankWrData` equals {high half, low half}.
- R3: The physical bank is the lowest set bit of the virtual bank's row in `mapMask` (row v occupies bits [v*8 +: 8] at default size). An all-zero row maps the bank to itself.
- R4: A write whose physical bank has `bankHold` low when its high half arrives appears on `bankWr*` in the next cycle. It carries that bank, the header address and the packed data, and no reorder-buffer tag.
- R5: A write whose bank is held when its high half arrives is parked. It appears on `bankWr*` in the cycle after the first cycle in which that bank's hold bit is low.
- R6: At most one parked write is released per cycle. When both park slots are releasable, the lower reorder-buffer tag goes first; on equal tags the DMA slot goes first.
- R7: `bankWrValid` presents one write per cycle in queue order. Writes entering the queue in the same cycle are ordered as: released parked write, then DMA write, then vector write.
- R8: A waiting read is issued on `bankRd*` only in a cycle in which `bankWrValid` is 1 and its physical bank's hold bit is 0. At most one read is issued per cycle.
- R9: A response on `bankRspValid` pops the oldest recorded requester tag. The data appear on that requester's response outputs in the next cycle, and never on both at once.
- R10: `idle` is 1 exactly when the write queue is empty, no requester tags are recorded and no response is being delivered.
- R11: `*WrReady` is 0 while that requester's park slot is occupied or while a first beat is pending, and while the queue holds more than depth-5 writes. `*RdReady` is 0 while that requester's read slot is occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dmaWrValid | input | 1 | DMA write beat valid |
| dmaWrTag | input | 4 | DMA reorder-buffer tag (first beat) |
| dmaWrBank | input | 3 | DMA virtual bank id (first beat) |
| dmaWrAddr | input | 12 | DMA start address (first beat) |
| dmaWrHalf | input | 64 | DMA data half, low then high |
| dmaWrReady | output | 1 | DMA first beat may be accepted |
| vecWrValid | input | 1 | Vector write beat valid |
| vecWrTag | input | 4 | Vector reorder-buffer tag |
| vecWrBank | input | 3 | Vector virtual bank id |
| vecWrAddr | input | 12 | Vector start address |
| vecWrHalf | input | 64 | Vector data half |
| vecWrReady | output | 1 | Vector first beat may be accepted |
| dmaRdValid | input | 1 | DMA read request |
| dmaRdBank | input | 3 | DMA read virtual bank |
| dmaRdAddr | input | 12 | DMA read address |
| dmaRdReady | output | 1 | DMA read slot free |
| vecRdValid | input | 1 | Vector read request |
| vecRdBank | input | 3 | Vector read virtual bank |
| vecRdAddr | input | 12 | Vector read address |
| vecRdReady | output | 1 | Vector read slot free |
| mapMask | input | 64 | Virtual-to-physical bank rows, one bit per physical bank |
| bankHold | input | 8 | Per-physical-bank outstanding dependency |
| bankWrValid | output | 1 | Write to bank array |
| bankWrBank | output | 3 | Physical bank of write |
| bankWrAddr | output | 12 | Write address |
| bankWrData | output | 128 | Write data |
| bankRdValid | output | 1 | Read to bank array |
| bankRdBank | output | 3 | Physical bank of read |
| bankRdAddr | output | 12 | Read address |
| bankRspValid | input | 1 | Bank read response valid |
| bankRspData | input | 128 | Bank read response data |
| dmaRspValid | output | 1 | Response to DMA engine |
| dmaRspData | output | 128 | Response data to DMA engine |
| vecRspValid | output | 1 | Response to vector unit |
| vecRspData | output | 128 | Response data to vector unit |
| idle | output | 1 | No queued writes, recorded tags or pending responses |

## Verification
Two pieces of queue entry can coincide: a parked write released by a falling hold bit, and a fresh write completing its high half. The bench parks a DMA write and then drops its hold in the very cycle the vector unit delivers the high half of a write to a clear bank. It judges the outcome by the order of the two writes on `bankWr*` over the next two cycles. A second coincidence, a read issue riding on a write forward, is judged by sampling `bankRdValid` and `bankWrValid` in the same cycle.

// File: rtl/spwr_pkg.sv
package spwr_pkg;
  localparam int HALF_W = 64;
  localparam int DATA_W = 2 * HALF_W;

  typedef enum logic { SRC_DMA = 1'b0, SRC_VEC = 1'b1 } src_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic [1:0] capLo;      // capture header and low half per source
    logic [1:0] parkLoad;   // completed write goes to its park slot
    logic [1:0] freshPush;  // completed write goes to the queue
    logic       relPush;    // a parked write goes to the queue
    logic       relSel;     // which park slot is released
    logic       pop;        // queue head leaves this cycle
    logic [1:0] rdLoad;     // read request enters its slot
    logic       rdRel;      // a read is issued to the banks
    logic       rdSel;      // which read slot is issued
    logic       rspLoad;    // bank response is steered this cycle
  } spwr_strobe_t;
endpackage

// File: rtl/spwr_bankmap.sv
module spwr_bankmap #(
  parameter int BANK_W = 3,
  localparam int BANKS = 1 << BANK_W
) (
  input  logic [BANKS*BANKS-1:0] mapMask,
  input  logic [BANK_W-1:0]      vbank,
  output logic [BANK_W-1:0]      pbank
);
  logic [BANKS-1:0] row;

  assign row = mapMask[int'(vbank)*BANKS +: BANKS];

  // descending scan: the lowest set bit is written last and wins
  always_comb begin
    pbank = vbank;
    for (int i = BANKS - 1; i >= 0; i--) begin
      if (row[i]) pbank = BANK_W'(i);
    end
  end
endmodule

// File: rtl/spwr_ctrl.sv
module spwr_ctrl
  import spwr_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int TAG_W  = 4,
  parameter int QDEPTH = 8,
  parameter int TDEPTH = 4,
  localparam int BANKS = 1 << BANK_W,
  localparam int QPW   = $clog2(QDEPTH),
  localparam int TPW   = $clog2(TDEPTH)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0]             wrValid,
  input  logic [1:0]             rdReqValid,
  input  logic [BANKS-1:0]       bankHold,
  input  logic                   bankRspValid,
  input  logic [1:0][BANK_W-1:0] freshBank,
  input  logic [1:0][BANK_W-1:0] parkBank,
  input  logic [1:0][TAG_W-1:0]  parkTag,
  input  logic [1:0][BANK_W-1:0] rdBank,
  input  logic                   rspBusy,
  output spwr_strobe_t           st,
  output logic [QPW-1:0]         qWrPtr,
  output logic [QPW-1:0]         qRdPtr,
  output logic [TPW-1:0]         tagWrPtr,
  output logic [TPW-1:0]         tagRdPtr,
  output logic [1:0]             wrReady,
  output logic [1:0]             rdReady,
  output logic                   bankWrValid,
  output logic                   idle
);
  localparam logic [QPW:0] ACCEPT_MAX  = (QPW+1)'(QDEPTH - 5);
  localparam logic [QPW:0] RELEASE_MAX = (QPW+1)'(QDEPTH - 3);
  localparam logic [TPW:0] TAG_FULL    = (TPW+1)'(TDEPTH);

  logic [1:0]   phaseHi;
  logic [1:0]   parkValid;
  logic [1:0]   rdSlotValid;
  logic [QPW:0] qCount;
  logic [TPW:0] tagCount;
  logic [1:0]   parkCand;
  logic [1:0]   rdCand;
  logic [QPW:0] pushCount;

  always_comb begin
    st = '0;
    for (int s = 0; s < 2; s++) begin
      wrReady[s]      = !phaseHi[s] && !parkValid[s] && (qCount <= ACCEPT_MAX);
      st.capLo[s]     = wrValid[s] && wrReady[s];
      st.freshPush[s] = phaseHi[s] && !bankHold[freshBank[s]];
      st.parkLoad[s]  = phaseHi[s] && bankHold[freshBank[s]];
      parkCand[s]     = parkValid[s] && !bankHold[parkBank[s]];
      rdReady[s]      = !rdSlotValid[s];
      st.rdLoad[s]    = rdReqValid[s] && rdReady[s];
      rdCand[s]       = rdSlotValid[s] && !bankHold[rdBank[s]];
    end
    st.relSel  = parkCand[1] && (!parkCand[0] || (parkTag[1] < parkTag[0]));
    st.relPush = (|parkCand) && (qCount <= RELEASE_MAX);
    st.pop     = (qCount != '0);
    st.rdSel   = !rdCand[0];
    st.rdRel   = st.pop && (|rdCand) && (tagCount < TAG_FULL);
    st.rspLoad = bankRspValid && (tagCount != '0);
    pushCount  = (QPW+1)'(st.relPush) + (QPW+1)'(st.freshPush[0]) + (QPW+1)'(st.freshPush[1]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseHi     <= '0;
      parkValid   <= '0;
      rdSlotValid <= '0;
      qCount      <= '0;
      qWrPtr      <= '0;
      qRdPtr      <= '0;
      tagCount    <= '0;
      tagWrPtr    <= '0;
      tagRdPtr    <= '0;
    end else begin
      phaseHi <= st.capLo;
      for (int s = 0; s < 2; s++) begin
        if (st.parkLoad[s]) parkValid[s] <= 1'b1;
        else if (st.relPush && (st.relSel == s[0])) parkValid[s] <= 1'b0;
        if (st.rdLoad[s]) rdSlotValid[s] <= 1'b1;
        else if (st.rdRel && (st.rdSel == s[0])) rdSlotValid[s] <= 1'b0;
      end
      qCount   <= qCount + pushCount - (QPW+1)'(st.pop);
      qWrPtr   <= qWrPtr + QPW'(pushCount);
      qRdPtr   <= qRdPtr + QPW'(st.pop);
      tagCount <= tagCount + (TPW+1)'(st.rdRel) - (TPW+1)'(st.rspLoad);
      tagWrPtr <= tagWrPtr + TPW'(st.rdRel);
      tagRdPtr <= tagRdPtr + TPW'(st.rspLoad);
    end
  end

  assign bankWrValid = st.pop;
  assign idle        = (qCount == '0) && (tagCount == '0) && !rspBusy;
endmodule

// File: rtl/spwr_datapath.sv
module spwr_datapath
  import spwr_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ADDR_W = 12,
  parameter int TAG_W  = 4,
  parameter int QDEPTH = 8,
  parameter int TDEPTH = 4,
  localparam int BANKS   = 1 << BANK_W,
  localparam int QPW     = $clog2(QDEPTH),
  localparam int TPW     = $clog2(TDEPTH),
  localparam int ENTRY_W = BANK_W + ADDR_W + DATA_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  spwr_strobe_t           st,
  input  logic [1:0][TAG_W-1:0]  wrTag,
  input  logic [1:0][BANK_W-1:0] wrVbank,
  input  logic [1:0][ADDR_W-1:0] wrAddr,
  input  logic [1:0][HALF_W-1:0] wrHalf,
  input  logic [1:0][BANK_W-1:0] rdVbank,
  input  logic [1:0][ADDR_W-1:0] rdAddr,
  input  logic [BANKS*BANKS-1:0] mapMask,
  input  logic [QPW-1:0]         qWrPtr,
  input  logic [QPW-1:0]         qRdPtr,
  input  logic [TPW-1:0]         tagWrPtr,
  input  logic [TPW-1:0]         tagRdPtr,
  input  logic [DATA_W-1:0]      bankRspData,
  output logic [1:0][BANK_W-1:0] freshBank,
  output logic [1:0][BANK_W-1:0] parkBank,
  output logic [1:0][TAG_W-1:0]  parkTag,
  output logic [1:0][BANK_W-1:0] rdBank,
  output logic [BANK_W-1:0]      bankWrBank,
  output logic [ADDR_W-1:0]      bankWrAddr,
  output logic [DATA_W-1:0]      bankWrData,
  output logic [BANK_W-1:0]      bankRdBank,
  output logic [ADDR_W-1:0]      bankRdAddr,
  output logic [1:0]             rspValid,
  output logic [DATA_W-1:0]      rspData
);
  logic [1:0][TAG_W-1:0]  hdrTag;
  logic [1:0][BANK_W-1:0] hdrVbank;
  logic [1:0][ADDR_W-1:0] hdrAddr;
  logic [1:0][HALF_W-1:0] hdrLo;
  logic [1:0][ENTRY_W-1:0] freshEntry;
  logic [1:0][ENTRY_W-1:0] parkEntry;
  logic [1:0][BANK_W-1:0] rdMapped;
  logic [1:0][ADDR_W-1:0] rdAddrQ;
  logic [ENTRY_W-1:0]     qMem [QDEPTH];
  logic                   tagMem [TDEPTH];
  logic [QPW-1:0]         idxRel, idxDma, idxVec;
  logic [ENTRY_W-1:0]     headEntry;

  for (genvar g = 0; g < 2; g++) begin : g_src
    spwr_bankmap #(.BANK_W(BANK_W)) u_wrMap (
      .mapMask(mapMask), .vbank(hdrVbank[g]), .pbank(freshBank[g]));
    spwr_bankmap #(.BANK_W(BANK_W)) u_rdMap (
      .mapMask(mapMask), .vbank(rdVbank[g]), .pbank(rdMapped[g]));
    assign freshEntry[g] = {freshBank[g], hdrAddr[g], wrHalf[g], hdrLo[g]};
    assign parkBank[g]   = parkEntry[g][ENTRY_W-1 -: BANK_W];
  end

  // storage without reset: headers, park slots, read slots, queue, tags
  always_ff @(posedge clk) begin
    for (int s = 0; s < 2; s++) begin
      if (st.capLo[s]) begin
        hdrTag[s]   <= wrTag[s];
        hdrVbank[s] <= wrVbank[s];
        hdrAddr[s]  <= wrAddr[s];
        hdrLo[s]    <= wrHalf[s];
      end
      if (st.parkLoad[s]) begin
        parkEntry[s] <= freshEntry[s];
        parkTag[s]   <= hdrTag[s];
      end
      if (st.rdLoad[s]) begin
        rdBank[s]  <= rdMapped[s];
        rdAddrQ[s] <= rdAddr[s];
      end
    end
    if (st.relPush)      qMem[idxRel] <= parkEntry[st.relSel];
    if (st.freshPush[0]) qMem[idxDma] <= freshEntry[0];
    if (st.freshPush[1]) qMem[idxVec] <= freshEntry[1];
    if (st.rdRel)        tagMem[tagWrPtr] <= st.rdSel;
    if (st.rspLoad)      rspData <= bankRspData;
  end

  always_comb begin
    idxRel = qWrPtr;
    idxDma = idxRel + QPW'(st.relPush);
    idxVec = idxDma + QPW'(st.freshPush[0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= '0;
    else begin
      rspValid[SRC_DMA] <= st.rspLoad && (tagMem[tagRdPtr] == SRC_DMA);
      rspValid[SRC_VEC] <= st.rspLoad && (tagMem[tagRdPtr] == SRC_VEC);
    end
  end

  assign headEntry  = qMem[qRdPtr];
  assign bankWrBank = headEntry[ENTRY_W-1 -: BANK_W];
  assign bankWrAddr = headEntry[DATA_W +: ADDR_W];
  assign bankWrData = headEntry[DATA_W-1:0];
  assign bankRdBank = rdBank[st.rdSel];
  assign bankRdAddr = rdAddrQ[st.rdSel];
endmodule

// File: rtl/spwr_router.sv
module spwr_router
  import spwr_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ADDR_W = 12,
  parameter int TAG_W  = 4,
  parameter int QDEPTH = 8,
  parameter int TDEPTH = 4,
  localparam int BANKS = 1 << BANK_W,
  localparam int QPW   = $clog2(QDEPTH),
  localparam int TPW   = $clog2(TDEPTH)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   dmaWrValid,
  input  logic [TAG_W-1:0]       dmaWrTag,
  input  logic [BANK_W-1:0]      dmaWrBank,
  input  logic [ADDR_W-1:0]      dmaWrAddr,
  input  logic [HALF_W-1:0]      dmaWrHalf,
  output logic                   dmaWrReady,
  input  logic                   vecWrValid,
  input  logic [TAG_W-1:0]       vecWrTag,
  input  logic [BANK_W-1:0]      vecWrBank,
  input  logic [ADDR_W-1:0]      vecWrAddr,
  input  logic [HALF_W-1:0]      vecWrHalf,
  output logic                   vecWrReady,
  input  logic                   dmaRdValid,
  input  logic [BANK_W-1:0]      dmaRdBank,
  input  logic [ADDR_W-1:0]      dmaRdAddr,
  output logic                   dmaRdReady,
  input  logic                   vecRdValid,
  input  logic [BANK_W-1:0]      vecRdBank,
  input  logic [ADDR_W-1:0]      vecRdAddr,
  output logic                   vecRdReady,
  input  logic [BANKS*BANKS-1:0] mapMask,
  input  logic [BANKS-1:0]       bankHold,
  output logic                   bankWrValid,
  output logic [BANK_W-1:0]      bankWrBank,
  output logic [ADDR_W-1:0]      bankWrAddr,
  output logic [DATA_W-1:0]      bankWrData,
  output logic                   bankRdValid,
  output logic [BANK_W-1:0]      bankRdBank,
  output logic [ADDR_W-1:0]      bankRdAddr,
  input  logic                   bankRspValid,
  input  logic [DATA_W-1:0]      bankRspData,
  output logic                   dmaRspValid,
  output logic [DATA_W-1:0]      dmaRspData,
  output logic                   vecRspValid,
  output logic [DATA_W-1:0]      vecRspData,
  output logic                   idle
);
  spwr_strobe_t           st;
  logic [QPW-1:0]         qWrPtr, qRdPtr;
  logic [TPW-1:0]         tagWrPtr, tagRdPtr;
  logic [1:0]             wrReady, rdReady, rspValid;
  logic [1:0][BANK_W-1:0] freshBank, parkBank, rdBank;
  logic [1:0][TAG_W-1:0]  parkTag;
  logic [DATA_W-1:0]      rspData;

  spwr_ctrl #(.BANK_W(BANK_W), .TAG_W(TAG_W), .QDEPTH(QDEPTH), .TDEPTH(TDEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrValid({vecWrValid, dmaWrValid}), .rdReqValid({vecRdValid, dmaRdValid}),
    .bankHold(bankHold), .bankRspValid(bankRspValid),
    .freshBank(freshBank), .parkBank(parkBank), .parkTag(parkTag), .rdBank(rdBank),
    .rspBusy(|rspValid), .st(st),
    .qWrPtr(qWrPtr), .qRdPtr(qRdPtr), .tagWrPtr(tagWrPtr), .tagRdPtr(tagRdPtr),
    .wrReady(wrReady), .rdReady(rdReady), .bankWrValid(bankWrValid), .idle(idle));

  spwr_datapath #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W),
                  .QDEPTH(QDEPTH), .TDEPTH(TDEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .st(st),
    .wrTag({vecWrTag, dmaWrTag}), .wrVbank({vecWrBank, dmaWrBank}),
    .wrAddr({vecWrAddr, dmaWrAddr}), .wrHalf({vecWrHalf, dmaWrHalf}),
    .rdVbank({vecRdBank, dmaRdBank}), .rdAddr({vecRdAddr, dmaRdAddr}),
    .mapMask(mapMask),
    .qWrPtr(qWrPtr), .qRdPtr(qRdPtr), .tagWrPtr(tagWrPtr), .tagRdPtr(tagRdPtr),
    .bankRspData(bankRspData),
    .freshBank(freshBank), .parkBank(parkBank), .parkTag(parkTag), .rdBank(rdBank),
    .bankWrBank(bankWrBank), .bankWrAddr(bankWrAddr), .bankWrData(bankWrData),
    .bankRdBank(bankRdBank), .bankRdAddr(bankRdAddr),
    .rspValid(rspValid), .rspData(rspData));

  assign dmaWrReady  = wrReady[SRC_DMA];
  assign vecWrReady  = wrReady[SRC_VEC];
  assign dmaRdReady  = rdReady[SRC_DMA];
  assign vecRdReady  = rdReady[SRC_VEC];
  assign bankRdValid = st.rdRel;
  assign dmaRspValid = rspValid[SRC_DMA];
  assign vecRspValid = rspValid[SRC_VEC];
  assign dmaRspData  = rspData;
  assign vecRspData  = rspData;
endmodule

// File: rtl/spwr_checker.sv
module spwr_checker #(
  parameter int BANK_W = 3,
  localparam int BANKS = 1 << BANK_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [BANKS-1:0]  bankHold,
  input logic              bankWrValid,
  input logic              bankRdValid,
  input logic [BANK_W-1:0] bankRdBank,
  input logic              bankRspValid,
  input logic              dmaRspValid,
  input logic              vecRspValid,
  input logic              idle
);
  // R8: reads ride only on cycles that forward a write
  assert_rd_with_wr_R8: assert property (@(posedge clk) disable iff (!rstN)
    bankRdValid |-> bankWrValid);

  // R8: an issued read never targets a held bank
  assert_rd_bank_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    bankRdValid |-> !bankHold[bankRdBank]);

  // R9: a response goes to exactly one requester
  assert_rsp_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dmaRspValid, vecRspValid}));

  // R9: a delivered response follows a bank response by one cycle
  assert_rsp_after_bank_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dmaRspValid || vecRspValid) |-> $past(bankRspValid));

  // R10: idle implies nothing leaves the block
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> (!bankWrValid && !bankRdValid && !dmaRspValid && !vecRspValid));
endmodule

bind spwr_router spwr_checker #(.BANK_W(BANK_W)) u_chk (
  .clk(clk), .rstN(rstN), .bankHold(bankHold), .bankWrValid(bankWrValid),
  .bankRdValid(bankRdValid), .bankRdBank(bankRdBank), .bankRspValid(bankRspValid),
  .dmaRspValid(dmaRspValid), .vecRspValid(vecRspValid), .idle(idle));

// File: tb/tb_spwr_router.sv
module tb_spwr_router;
  logic clk = 1'b0;
  logic rstN;
  logic dmaWrValid, vecWrValid, dmaRdValid, vecRdValid, bankRspValid;
  logic [3:0] dmaWrTag, vecWrTag;
  logic [2:0] dmaWrBank, vecWrBank, dmaRdBank, vecRdBank;
  logic [11:0] dmaWrAddr, vecWrAddr, dmaRdAddr, vecRdAddr;
  logic [63:0] dmaWrHalf, vecWrHalf, mapMask;
  logic [7:0] bankHold;
  logic [127:0] bankRspData;
  logic dmaWrReady, vecWrReady, dmaRdReady, vecRdReady;
  logic bankWrValid, bankRdValid, dmaRspValid, vecRspValid, idle;
  logic [2:0] bankWrBank, bankRdBank;
  logic [11:0] bankWrAddr, bankRdAddr;
  logic [127:0] bankWrData, dmaRspData, vecRspData;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  spwr_router dut (.*);

  typedef struct packed {
    logic        src;
    logic [3:0]  tag;
    logic [2:0]  vb;
    logic [11:0] addr;
    logic [63:0] lo;
    logic [63:0] hi;
    logic [2:0]  pb;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 4'd1, 3'd2, 12'h010, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 3'd4},
    '{1'b1, 4'd2, 3'd5, 12'h020, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 3'd5},
    '{1'b0, 4'd3, 3'd7, 12'h030, 64'hDEAD_BEEF_0000_0001, 64'hCAFE_F00D_0000_0002, 3'd0},
    '{1'b1, 4'd4, 3'd6, 12'h040, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 3'd6},
    '{1'b0, 4'd5, 3'd0, 12'h050, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 3'd0},
    '{1'b1, 4'd6, 3'd3, 12'hFFF, 64'hA5A5_A5A5_5A5A_5A5A, 64'h3C3C_C3C3_3C3C_C3C3, 3'd3}
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drvWr(input logic src, input logic v, input logic [3:0] tag,
                       input logic [2:0] vb, input logic [11:0] a, input logic [63:0] h);
    if (!src) begin
      dmaWrValid = v; dmaWrTag = tag; dmaWrBank = vb; dmaWrAddr = a; dmaWrHalf = h;
    end else begin
      vecWrValid = v; vecWrTag = tag; vecWrBank = vb; vecWrAddr = a; vecWrHalf = h;
    end
  endtask

  task automatic smp();
    #4;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    drvWr(1'b0, 1'b0, '0, '0, '0, '0);
    drvWr(1'b1, 1'b0, '0, '0, '0, '0);
    dmaRdValid = 0; vecRdValid = 0; dmaRdBank = 0; vecRdBank = 0;
    dmaRdAddr = 0; vecRdAddr = 0; bankRspValid = 0; bankRspData = 0;
    bankHold = 0; mapMask = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    smp();
    chk("R1 idle", idle, 1);
    chk("R1 bankWrValid", bankWrValid, 0);
    chk("R1 bankRdValid", bankRdValid, 0);
    chk("R1 rsp valids", {dmaRspValid, vecRspValid}, 0);
    chk("R1 ready", {dmaWrReady, vecWrReady, dmaRdReady, vecRdReady}, 4'hF);

    // table walk: packing, mapping, direct queue entry (R2 R3 R4)
    mapMask = '0;
    mapMask[2*8 +: 8] = 8'b0101_0000;
    mapMask[7*8 +: 8] = 8'b1000_0001;
    mapMask[6*8 +: 8] = 8'b1100_0000;
    foreach (VECS[i]) begin
      @(negedge clk);
      drvWr(VECS[i].src, 1'b1, VECS[i].tag, VECS[i].vb, VECS[i].addr, VECS[i].lo);
      @(negedge clk);
      drvWr(VECS[i].src, 1'b1, VECS[i].tag, VECS[i].vb, VECS[i].addr, VECS[i].hi);
      @(negedge clk);
      drvWr(VECS[i].src, 1'b0, '0, '0, '0, '0);
      smp();
      chk("R4 forward valid", bankWrValid, 1);
      chk("R3 mapped bank", bankWrBank, VECS[i].pb);
      chk("R4 address", bankWrAddr, VECS[i].addr);
      chk("R2 packed data", bankWrData, {VECS[i].hi, VECS[i].lo});
      @(negedge clk);
      smp();
      chk("R7 single forward", bankWrValid, 0);
    end
    mapMask = '0;

    // R5 parked write released after hold drops; R11 ready while parked
    bankHold = 8'b0000_1000;
    @(negedge clk); drvWr(1'b0, 1'b1, 4'd7, 3'd3, 12'h100, 64'hA1);
    @(negedge clk); drvWr(1'b0, 1'b1, 4'd7, 3'd3, 12'h100, 64'hB1);
    @(negedge clk); drvWr(1'b0, 1'b0, '0, '0, '0, '0); smp();
    chk("R5 parked not forwarded", bankWrValid, 0);
    chk("R11 ready low while parked", dmaWrReady, 0);
    @(negedge clk); bankHold = '0; smp();
    chk("R5 no forward in release cycle", bankWrValid, 0);
    @(negedge clk); smp();
    chk("R5 forwarded after release", bankWrValid, 1);
    chk("R5 bank", bankWrBank, 3);
    chk("R5 data", bankWrData, {64'hB1, 64'hA1});
    chk("R11 ready back", dmaWrReady, 1);

    // R6 lower tag released first
    bankHold = 8'b0000_0110;
    @(negedge clk); drvWr(1'b0, 1'b1, 4'd9, 3'd1, 12'h200, 64'h1); drvWr(1'b1, 1'b1, 4'd4, 3'd2, 12'h300, 64'h2);
    @(negedge clk); drvWr(1'b0, 1'b1, 4'd9, 3'd1, 12'h200, 64'h3); drvWr(1'b1, 1'b1, 4'd4, 3'd2, 12'h300, 64'h4);
    @(negedge clk); drvWr(1'b0, 1'b0, '0, '0, '0, '0); drvWr(1'b1, 1'b0, '0, '0, '0, '0); bankHold = '0; smp();
    chk("R6 nothing yet", bankWrValid, 0);
    @(negedge clk); smp();
    chk("R6 lower tag first", {bankWrValid, bankWrBank}, {1'b1, 3'd2});
    @(negedge clk); smp();
    chk("R6 higher tag second", {bankWrValid, bankWrBank}, {1'b1, 3'd1});

    // R6 equal tags: DMA slot first
    bankHold = 8'b0000_0110;
    @(negedge clk); drvWr(1'b0, 1'b1, 4'd5, 3'd1, 12'h200, 64'h1); drvWr(1'b1, 1'b1, 4'd5, 3'd2, 12'h300, 64'h2);
    @(negedge clk); drvWr(1'b0, 1'b1, 4'd5, 3'd1, 12'h200, 64'h3); drvWr(1'b1, 1'b1, 4'd5, 3'd2, 12'h300, 64'h4);
    @(negedge clk); drvWr(1'b0, 1'b0, '0, '0, '0, '0); drvWr(1'b1, 1'b0, '0, '0, '0, '0); bankHold = '0;
    @(negedge clk); smp();
    chk("R6 tie DMA first", {bankWrValid, bankWrBank}, {1'b1, 3'd1});
    @(negedge clk); smp();
    chk("R6 tie vector second", {bankWrValid, bankWrBank}, {1'b1, 3'd2});

    // R7 release and fresh write in the same cycle
    bankHold = 8'b0000_0010;
    @(negedge clk); drvWr(1'b0, 1'b1, 4'd2, 3'd1, 12'h111, 64'h10);
    @(negedge clk); drvWr(1'b0, 1'b1, 4'd2, 3'd1, 12'h111, 64'h11);
    @(negedge clk); drvWr(1'b0, 1'b0, '0, '0, '0, '0); drvWr(1'b1, 1'b1, 4'd3, 3'd6, 12'h666, 64'h60);
    @(negedge clk); drvWr(1'b1, 1'b1, 4'd3, 3'd6, 12'h666, 64'h61); bankHold = '0;
    @(negedge clk); drvWr(1'b1, 1'b0, '0, '0, '0, '0); smp();
    chk("R7 released parked first", {bankWrValid, bankWrBank, bankWrAddr}, {1'b1, 3'd1, 12'h111});
    @(negedge clk); smp();
    chk("R7 fresh vector second", {bankWrValid, bankWrBank, bankWrAddr}, {1'b1, 3'd6, 12'h666});

    // R7 both sources complete in the same cycle
    @(negedge clk); drvWr(1'b0, 1'b1, 4'd1, 3'd4, 12'h044, 64'h40); drvWr(1'b1, 1'b1, 4'd1, 3'd5, 12'h055, 64'h50);
    @(negedge clk); drvWr(1'b0, 1'b1, 4'd1, 3'd4, 12'h044, 64'h41); drvWr(1'b1, 1'b1, 4'd1, 3'd5, 12'h055, 64'h51);
    @(negedge clk); drvWr(1'b0, 1'b0, '0, '0, '0, '0); drvWr(1'b1, 1'b0, '0, '0, '0, '0); smp();
    chk("R7 DMA before vector", {bankWrValid, bankWrBank}, {1'b1, 3'd4});
    @(negedge clk); smp();
    chk("R7 vector after DMA", {bankWrValid, bankWrBank}, {1'b1, 3'd5});

    // R8 read issue rides on write forwards; R9 steering; R10 idle
    @(negedge clk);
    dmaRdValid = 1; dmaRdBank = 3'd4; dmaRdAddr = 12'h011;
    vecRdValid = 1; vecRdBank = 3'd5; vecRdAddr = 12'h022;
    bankHold = 8'b0010_0000;
    @(negedge clk); dmaRdValid = 0; vecRdValid = 0; smp();
    chk("R8 no read without write", bankRdValid, 0);
    chk("R11 read slot busy", {dmaRdReady, vecRdReady}, 2'b00);
    @(negedge clk); smp();
    chk("R8 still waiting", bankRdValid, 0);
    @(negedge clk); drvWr(1'b0, 1'b1, 4'd1, 3'd0, 12'h001, 64'h70);
    @(negedge clk); drvWr(1'b0, 1'b1, 4'd1, 3'd0, 12'h001, 64'h71);
    @(negedge clk); drvWr(1'b0, 1'b0, '0, '0, '0, '0); smp();
    chk("R8 read with write", {bankWrValid, bankRdValid, bankRdBank, bankRdAddr}, {1'b1, 1'b1, 3'd4, 12'h011});
    @(negedge clk); bankHold = '0; smp();
    chk("R8 held read waits for write", bankRdValid, 0);
    @(negedge clk); drvWr(1'b1, 1'b1, 4'd2, 3'd0, 12'h002, 64'h80);
    @(negedge clk); drvWr(1'b1, 1'b1, 4'd2, 3'd0, 12'h002, 64'h81);
    @(negedge clk); drvWr(1'b1, 1'b0, '0, '0, '0, '0); smp();
    chk("R8 second read", {bankRdValid, bankRdBank, bankRdAddr}, {1'b1, 3'd5, 12'h022});
    @(negedge clk); bankRspValid = 1; bankRspData = {64'hAAAA, 64'h0001}; smp();
    chk("R10 not idle with tags", idle, 0);
    @(negedge clk); bankRspData = {64'hBBBB, 64'h0002}; smp();
    chk("R9 first response to DMA", {dmaRspValid, vecRspValid}, 2'b10);
    chk("R9 DMA data", dmaRspData, {64'hAAAA, 64'h0001});
    @(negedge clk); bankRspValid = 0; smp();
    chk("R9 second response to vector", {dmaRspValid, vecRspValid}, 2'b01);
    chk("R9 vector data", vecRspData, {64'hBBBB, 64'h0002});
    chk("R10 not idle while delivering", idle, 0);
    @(negedge clk); smp();
    chk("R10 idle when drained", idle, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule